// File: doc/BRIEF.md
# Cache-Side Event Counter Block

This block counts micro-architectural events for a shared cache. Eight 64-bit counters each pick one line out of a 256-wide event input vector through an 8-bit event code. A counter advances by one in every clock cycle in which its selected line is high. For that to happen, its own enable bit and a global enable bit in the same control word must both be set. Software reaches everything through a simple register bus. The bus carries 32-bit or 64-bit accesses. Software can preload or read any counter, pack event codes four to a 32-bit select word, and handle overflow through a mask, status and write-one-to-clear register set that drives a single interrupt line.

A two-state access machine sits in front of the registers. In `BUS_IDLE` it waits for `bus_valid`. The transition ACCEPT latches the request and moves to `BUS_RESP`. In `BUS_RESP` it raises `bus_ready` for one cycle and returns read data. Any write takes effect at the clock edge that ends this cycle. The transition COMPLETE then returns the machine to `BUS_IDLE` unconditionally.

Top module: `cache_perf_monitor`

## Requirements
- R1: After reset all counters, the control word, the event codes and the status register read 0, the mask register (0x0800) reads 0xFF and `irq` is low.
- R2: Counter n increments by exactly one in each cycle where event line `evt_in[code_n]` is high. Control bit n (0x1C00) and global bit 26 of the control word must both be 1 at the same time. If either is 0, the counter holds.
- R3: The event code of counter n is byte lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)) of the select word at 0x1D00 + 4*(n/4). Any 8-bit value is legal.
- R4: Counter n sits at 0x1E00 + 8*n. A 64-bit access moves the whole value. A 32-bit access at +0 reaches bits 31:0, and one at +4 reaches bits 63:32 (returned in rdata bits 31:0). Each half write leaves the other half unchanged.
- R5: A bus write to a counter in the same cycle as an increment wins. The counter takes exactly the written value.
- R6: When a counter steps from all ones to zero, status bit n (0x0808) becomes 1.
- R7: Writing 1 to bit n of 0x080C clears status bit n. Writing 0 there has no effect, and writes to the status register itself are ignored.
- R8: `irq` is high exactly when some status bit n is 1 while mask bit n is 0. A mask bit of 1 blocks counter n.
- R9: 0x1CF0 reads the `VERSION` parameter and ignores writes.
- R10: `bus_ready` rises in the cycle after a request is accepted and lasts one cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | DATA_W | Read data, valid with bus_ready |
| evt_in | input | NUM_EVT | Event lines, indexed by event code |
| irq | output | 1 | Unmasked overflow interrupt |

## Verification
Most internal faults show up at the ports within one access of the fault. A wrong event-code lane shows as a counter that stays at zero or counts a different line's pulses. An enable decoded on the wrong bit shows as a count that differs from the number of cycles the event line was held. A lost write priority returns the preload plus the increments made during the write cycle. Status or mask faults appear on `irq` and in the status readback right after the edge that wraps, masks or clears.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam logic [15:0] OFS_MASK = 16'h0800;
    localparam logic [15:0] OFS_STAT = 16'h0808;
    localparam logic [15:0] OFS_CLR  = 16'h080C;
    localparam logic [15:0] OFS_CTRL = 16'h1C00;
    localparam logic [15:0] OFS_VER  = 16'h1CF0;
    localparam logic [15:0] OFS_SEL  = 16'h1D00;
    localparam logic [15:0] OFS_CNT  = 16'h1E00;
    localparam int          GLB_BIT  = 26;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/pm_bus_fsm.sv
module pm_bus_fsm #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_dword,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              acc_wr,
    output logic              acc_dword,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);
    import pm_pkg::*;

    bus_state_e st_q, st_d;
    logic              wr_q, dw_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (bus_valid) st_d = BUS_RESP;   // ACCEPT
            BUS_RESP: st_d = BUS_IDLE;                  // COMPLETE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            dw_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (st_q == BUS_IDLE && bus_valid) begin
            wr_q    <= bus_write;
            dw_q    <= bus_dword;
            addr_q  <= bus_addr;
            wdata_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_ready = (st_q == BUS_RESP);
        acc_wr    = (st_q == BUS_RESP) && wr_q;
        acc_dword = dw_q;
        acc_addr  = addr_q;
        acc_wdata = wdata_q;
    end

    // R10: one-cycle completion pulse
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && bus_valid) |=> bus_ready);
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int CNT_W   = 64,
    parameter int CODE_W  = 8,
    parameter int NUM_EVT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [CODE_W-1:0]  code,
    input  logic               cnt_en,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic [CNT_W-1:0]   ld_data,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic evt_hit, inc, load;

    assign evt_hit = evt_in[code];
    assign inc     = cnt_en & evt_hit;
    assign load    = ld_lo | ld_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            if (ld_lo) cnt[31:0]       <= ld_data[31:0];
            if (ld_hi) cnt[CNT_W-1:32] <= ld_data[CNT_W-1:32];
        end else if (inc) begin
            cnt <= cnt + ONE;
        end
    end

    assign wrap = inc & ~load & (&cnt);

    // R2: single step when gated on, hold otherwise
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && evt_hit && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + ONE));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cnt_en && evt_hit) && !ld_lo && !ld_hi) |=> $stable(cnt));
    // R5: full write beats an increment
    assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && ld_hi) |=> (cnt == $past(ld_data)));
endmodule

// File: rtl/pm_irq.sv
module pm_irq #(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] wrap,
    input  logic [NUM_CNT-1:0] clr_vec,
    input  logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] status,
    output logic               irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | wrap;
    end

    assign irq = |(status & ~mask);

    // R6: a wrap is recorded
    assert_wrap_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((status & $past(wrap)) == $past(wrap)));
    // R7: write-one clears, nothing else moves status
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~wrap)) |=> ((status & $past(clr_vec & ~wrap)) == '0));
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0 && wrap == '0) |=> $stable(status));
    // R8: fully masked means silent
    assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);
endmodule

// File: rtl/cache_perf_monitor.sv
module cache_perf_monitor #(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 64,
    parameter int          CODE_W  = 8,
    parameter int          NUM_EVT = 256,
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 64,
    parameter logic [31:0] VERSION = 32'h0000_0120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic               bus_dword,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_ready,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    import pm_pkg::*;

    localparam int SEL_REGS = (NUM_CNT + 3) / 4;
    localparam int SELW_W   = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1;
    localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam int HI_W     = CNT_W - 32;
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] SEL_LO = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] SEL_HI = ADDR_W'(int'(OFS_SEL) + 4 * SEL_REGS);
    localparam logic [ADDR_W-1:0] CNT_LO = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] CNT_HI = ADDR_W'(int'(OFS_CNT) + 8 * NUM_CNT);

    logic              acc_wr, acc_dword;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;

    pm_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_dword(bus_dword),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .acc_wr(acc_wr), .acc_dword(acc_dword),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    // address decode
    logic              in_sel, in_cnt, cnt_half;
    logic [ADDR_W-1:0] sel_off, cnt_off;
    logic [SELW_W-1:0] sel_word;
    logic [IDX_W-1:0]  cnt_idx;

    assign in_sel   = (acc_addr >= SEL_LO) && (acc_addr < SEL_HI);
    assign in_cnt   = (acc_addr >= CNT_LO) && (acc_addr < CNT_HI);
    assign sel_off  = acc_addr - SEL_LO;
    assign cnt_off  = acc_addr - CNT_LO;
    assign sel_word = sel_off[SELW_W+1:2];
    assign cnt_idx  = cnt_off[IDX_W+2:3];
    assign cnt_half = cnt_off[2];

    // control and mask words
    logic [NUM_CNT-1:0] en_q, mask_q, status, clr_vec, wrap_vec;
    logic               glb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            glb_q  <= 1'b0;
            mask_q <= '1;
        end else if (acc_wr) begin
            if (acc_addr == A_CTRL) begin
                en_q  <= acc_wdata[NUM_CNT-1:0];
                glb_q <= acc_wdata[GLB_BIT];
            end
            if (acc_addr == A_MASK) mask_q <= acc_wdata[NUM_CNT-1:0];
        end
    end

    assign clr_vec = (acc_wr && acc_addr == A_CLR) ? acc_wdata[NUM_CNT-1:0] : '0;

    // counter load data: halves selected by access width
    logic [HI_W-1:0]  hi_val;
    logic [CNT_W-1:0] ld_data;
    assign hi_val  = acc_dword ? acc_wdata[CNT_W-1:32] : acc_wdata[HI_W-1:0];
    assign ld_data = {hi_val, acc_wdata[31:0]};

    logic [CODE_W-1:0] code_vec [NUM_CNT];
    logic [CNT_W-1:0]  cnt_val  [NUM_CNT];

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic              code_we, idx_hit, ld_lo, ld_hi;
        logic [CODE_W-1:0] code_r;

        assign code_we = acc_wr && in_sel && (sel_word == SELW_W'(n / 4));
        assign idx_hit = acc_wr && in_cnt && (cnt_idx == IDX_W'(n));
        assign ld_lo   = idx_hit && (acc_dword || !cnt_half);
        assign ld_hi   = idx_hit && (acc_dword ||  cnt_half);

        always_ff @(posedge clk) begin
            if (!rst_n)       code_r <= '0;
            else if (code_we) code_r <= acc_wdata[(n % 4) * 8 +: CODE_W];
        end
        assign code_vec[n] = code_r;

        pm_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_EVT(NUM_EVT)) u_ctr (
            .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .code(code_r),
            .cnt_en(en_q[n] & glb_q), .ld_lo(ld_lo), .ld_hi(ld_hi),
            .ld_data(ld_data), .cnt(cnt_val[n]), .wrap(wrap_vec[n])
        );
    end

    pm_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk(clk), .rst_n(rst_n), .wrap(wrap_vec), .clr_vec(clr_vec),
        .mask(mask_q), .status(status), .irq(irq)
    );

    // read mux
    logic [DATA_W-1:0] rd;
    always_comb begin
        rd = '0;
        if (acc_addr == A_CTRL) begin
            rd[NUM_CNT-1:0] = en_q;
            rd[GLB_BIT]     = glb_q;
        end
        if (acc_addr == A_MASK) rd[NUM_CNT-1:0] = mask_q;
        if (acc_addr == A_STAT) rd[NUM_CNT-1:0] = status;
        if (acc_addr == A_VER)  rd[31:0] = VERSION;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (in_sel && sel_word == SELW_W'(n / 4))
                rd[(n % 4) * 8 +: CODE_W] = code_vec[n];
            if (in_cnt && cnt_idx == IDX_W'(n)) begin
                if (acc_dword)     rd = DATA_W'(cnt_val[n]);
                else if (cnt_half) rd[HI_W-1:0] = cnt_val[n][CNT_W-1:32];
                else               rd[31:0] = cnt_val[n][31:0];
            end
        end
    end

    assign bus_rdata = bus_ready ? rd : '0;

    // R1: the mask leaves reset fully set until software writes it
    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && $past(!rst_n)) |-> (mask_q == '1));
endmodule

// File: tb/sim_cache_perf_monitor.sv
`timescale 1ns/1ps
module sim_cache_perf_monitor;
    localparam logic [31:0] VER = 32'h0000_0120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_dword = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ready;
    logic [63:0] bus_rdata;
    logic [255:0] evt_in = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cache_perf_monitor #(.VERSION(VER)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_dword(bus_dword), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic        dw;
        logic [15:0] addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 16'h1C00, 64'h0, 64'h0, 4'd1},                    // R1 control
        '{1'b0, 1'b0, 16'h0800, 64'h0, 64'hFF, 4'd1},                   // R1 mask
        '{1'b0, 1'b0, 16'h0808, 64'h0, 64'h0, 4'd1},                    // R1 status
        '{1'b0, 1'b0, 16'h1CF0, 64'h0, 64'(VER), 4'd9},                 // R9 version
        '{1'b0, 1'b1, 16'h1E38, 64'h0, 64'h0, 4'd1},                    // R1 counter 7
        '{1'b1, 1'b1, 16'h1E08, 64'h1122334455667788, 64'h0, 4'd4},     // R4 preload
        '{1'b0, 1'b1, 16'h1E08, 64'h0, 64'h1122334455667788, 4'd4},     // R4 dword read
        '{1'b0, 1'b0, 16'h1E0C, 64'h0, 64'h11223344, 4'd4},             // R4 high half
        '{1'b1, 1'b0, 16'h1E08, 64'hAABBCCDD, 64'h0, 4'd4},             // R4 low write
        '{1'b0, 1'b1, 16'h1E08, 64'h0, 64'h11223344AABBCCDD, 4'd4},     // R4
        '{1'b1, 1'b0, 16'h1E0C, 64'h55667788, 64'h0, 4'd4},             // R4 high write
        '{1'b0, 1'b1, 16'h1E08, 64'h0, 64'h55667788AABBCCDD, 4'd4},     // R4
        '{1'b1, 1'b0, 16'h1D04, 64'h44332211, 64'h0, 4'd3},             // R3 codes 4..7
        '{1'b0, 1'b0, 16'h1D04, 64'h0, 64'h44332211, 4'd3},             // R3
        '{1'b0, 1'b0, 16'h1D00, 64'h0, 64'h0, 4'd3},                    // R3 word 0 untouched
        '{1'b1, 1'b0, 16'h1CF0, 64'hFFFF, 64'h0, 4'd9},                 // R9 write ignored
        '{1'b0, 1'b0, 16'h1CF0, 64'h0, 64'(VER), 4'd9},                 // R9
        '{1'b0, 1'b0, 16'h0100, 64'h0, 64'h0, 4'd10}                    // R10 unmapped
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge after the write commits
    task automatic access(input logic wr, input logic dw, input logic [15:0] a,
                          input logic [63:0] d, output logic [63:0] rdv);
        bus_valid = 1'b1; bus_write = wr; bus_dword = dw; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        check("R10 ready", 64'(bus_ready), 64'h1);
        rdv = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        check("R10 ready drop", 64'(bus_ready), 64'h0);
    endtask

    task automatic wr(input logic dw, input logic [15:0] a, input logic [63:0] d);
        logic [63:0] unused_rd;
        access(1'b1, dw, a, d, unused_rd);
    endtask

    task automatic rd_chk(input string tag, input logic dw, input logic [15:0] a,
                          input logic [63:0] exp);
        logic [63:0] v;
        access(1'b0, dw, a, 64'h0, v);
        check(tag, v, exp);
    endtask

    task automatic pulse(input logic [7:0] c, input int k);
        evt_in[c] = 1'b1;
        repeat (k) @(posedge clk);
        @(negedge clk);
        evt_in[c] = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 64'(irq), 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            access(TBL[i].wr, TBL[i].dw, TBL[i].addr, TBL[i].data, v);
            if (!TBL[i].wr) begin
                n_chk++;
                if (v !== TBL[i].exp) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             TBL[i].req, i, v, TBL[i].exp);
                end
            end
        end

        // R2: local enable without global enable holds
        wr(1'b0, 16'h1D04, 64'h0000_9500);          // counter 5 code 0x95
        wr(1'b1, 16'h1E28, 64'h0);
        wr(1'b0, 16'h1C00, 64'h0000_0020);
        pulse(8'h95, 4);
        rd_chk("R2 no global enable", 1'b1, 16'h1E28, 64'h0);

        // R2: both enables, count equals cycles held
        wr(1'b0, 16'h1C00, 64'h0400_0020);
        pulse(8'h95, 6);
        rd_chk("R2 count six", 1'b1, 16'h1E28, 64'd6);
        rd_chk("R2 disabled counter 1 holds", 1'b1, 16'h1E08, 64'h55667788AABBCCDD);

        // R3: counter 2 selects line 0x10 via lane 2 of word 0
        wr(1'b0, 16'h1D00, 64'h0010_0000);
        wr(1'b1, 16'h1E10, 64'h0);
        wr(1'b0, 16'h1C00, 64'h0400_0024);
        pulse(8'h10, 3);
        rd_chk("R3 counter 2 lane", 1'b1, 16'h1E10, 64'd3);
        rd_chk("R3 counter 5 untouched", 1'b1, 16'h1E28, 64'd6);

        // R5: write during continuous counting
        evt_in[8'h95] = 1'b1;
        wr(1'b1, 16'h1E28, 64'h1000);
        evt_in[8'h95] = 1'b0;
        rd_chk("R5 write wins", 1'b1, 16'h1E28, 64'h1000);

        // R6 / R8 / R7: wrap counter 2
        wr(1'b1, 16'h1E10, 64'hFFFF_FFFF_FFFF_FFFE);
        pulse(8'h10, 2);
        rd_chk("R6 status after wrap", 1'b0, 16'h0808, 64'h4);
        rd_chk("R6 wrapped to zero", 1'b1, 16'h1E10, 64'h0);
        check("R8 masked irq low", 64'(irq), 64'h0);
        wr(1'b0, 16'h0800, 64'hFB);
        check("R8 unmasked irq high", 64'(irq), 64'h1);
        wr(1'b0, 16'h080C, 64'h0);
        rd_chk("R7 zero clear no effect", 1'b0, 16'h0808, 64'h4);
        wr(1'b0, 16'h080C, 64'h4);
        rd_chk("R7 cleared", 1'b0, 16'h0808, 64'h0);
        check("R8 irq after clear", 64'(irq), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule